// File: doc/BRIEF.md
# Descriptor-Driven Buffer Fetch Engine

This engine feeds an on-chip sample sink from buffers scattered across system memory. Software places a table of 8-byte descriptors in memory and programs the table's base address. Each descriptor names one buffer by its start address and byte count. On a start command the engine walks the table. For each entry it reads the buffer word by word and passes each 32-bit word to the sink. Every delivered word also holds the attached processor core for exactly one cycle.

Two control bits sit in each descriptor's count word. One marks the last entry of the table. The other flags the entry so that software can be told when it completes. At the last entry the engine either goes idle or, with looping enabled, wraps back to the first entry and carries on until software writes a stop command.

Memory is reached through a single-beat read port: the engine raises a request and holds it until the response arrives. Software uses a small register port. The command register carries start, stop, loop and two interrupt enables. The status register reports activity and two sticky event bits.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset, mem_req, snk_valid, core_stall and irq are low, and the status register (address 2) reads 0.
- R2: Writing bit 0 to the command register (address 0) while idle makes the engine read the descriptor's address word at the table base (address 1, bits 1:0 forced to zero), and then the count word at base+4.
- R3: A descriptor with byte count N (count word bits 23:0) produces ceil(N/4) reads at ascending word addresses from the buffer start (bits 1:0 forced to zero). Each read value appears on snk_data with snk_valid high for one cycle.
- R4: core_stall is high in exactly the cycles in which snk_valid is high, and is never high for two cycles in a row.
- R5: A descriptor whose byte count is zero produces no data read. The engine then fetches the next descriptor, 8 bytes further on.
- R6: When a descriptor with count-word bit 31 set completes and looping is off, status bit 1 is set, status bit 0 (active) clears, and no further memory reads occur.
- R7: With loop enable (command bit 2) set, the completion of a bit-31 descriptor is followed by a fresh fetch from the table base.
- R8: A stop command (command bit 1) lets the word in flight finish and be delivered, at most one word. The engine then goes idle with status bit 0 clear and issues no further reads.
- R9: A completed descriptor with count-word bit 30 set sets status bit 2. Count-word bits 29:24 do not change the number of words fetched.
- R10: irq equals (status bit 1 AND command bit 3) OR (status bit 2 AND command bit 4). Writing a 1 to status bit 1 or bit 2 clears that bit.
- R11: While mem_req is high and mem_ack is low, mem_req stays high next cycle with mem_addr unchanged. Every requested address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 table base, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | AW | Byte address of the requested word |
| mem_ack | input | 1 | Read response valid, one cycle |
| mem_rdata | input | 32 | Read response data |
| snk_valid | output | 1 | Sample word valid for one cycle |
| snk_data | output | 32 | Sample word to the sink |
| core_stall | output | 1 | Holds the processor core for one cycle per word |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the memory side pulses mem_ack for one cycle and only while mem_req is high, and that no new acknowledge arrives in the cycle after one. The bench's memory model keeps to this: it answers each request after a configurable wait and then drops the acknowledge. Register writes land on falling clock edges and last one cycle, so every command reaches the engine as a single clean strobe. The stop command is issued while reads are in progress, so that the assertions see the engine leave an active fetch and not only an idle one.

// File: rtl/sg_dma_engine.sv
module sg_dma_engine #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          snk_valid,
  output logic [31:0]   snk_data,
  output logic          core_stall,
  output logic          irq
);
  localparam int WW = CW - 1;

  typedef enum logic [2:0] {S_IDLE, S_DADR, S_DCNT, S_DATA, S_PUSH} st_t;

  st_t           state;
  logic [AW-1:0] base, desc_ptr, buf_ptr;
  logic [WW-1:0] wleft;
  logic [31:0]   data_q;
  logic          eol_q, flag_q, loop_en, eol_ie, flag_ie;
  logic          st_eol, st_flag, stop_pend;

  wire active  = state != S_IDLE;
  wire cmd_wr  = reg_wr && reg_addr == 2'd0;
  wire sts_wr  = reg_wr && reg_addr == 2'd2;
  wire start   = cmd_wr && reg_wdata[0] && !active;
  wire stop    = cmd_wr && reg_wdata[1] && active;
  wire stop_now = stop_pend || stop;

  logic [CW:0] wsum;
  assign wsum = {1'b0, mem_rdata[CW-1:0]} + (CW+1)'(3);
  wire [WW-1:0] words = wsum[CW:2];

  wire zero_done = state == S_DCNT && mem_ack && words == '0;
  wire last_done = state == S_PUSH && wleft == WW'(1);
  wire done_now  = zero_done || last_done;
  wire cur_eol   = (state == S_DCNT) ? mem_rdata[31] : eol_q;
  wire cur_flag  = (state == S_DCNT) ? mem_rdata[30] : flag_q;

  assign mem_req    = state == S_DADR || state == S_DCNT || state == S_DATA;
  assign mem_addr   = (state == S_DATA) ? buf_ptr :
                      (state == S_DCNT) ? desc_ptr + AW'(4) : desc_ptr;
  assign snk_valid  = state == S_PUSH;
  assign core_stall = state == S_PUSH;
  assign snk_data   = data_q;
  assign irq        = (st_eol && eol_ie) || (st_flag && flag_ie);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {27'd0, flag_ie, eol_ie, loop_en, 2'b00};
      2'd1:    reg_rdata = 32'(base);
      2'd2:    reg_rdata = {29'd0, st_flag, st_eol, active};
      default: reg_rdata = 32'd0;
    endcase
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, mem_rdata, reg_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      base <= '0; desc_ptr <= '0; buf_ptr <= '0; wleft <= '0; data_q <= '0;
      eol_q <= 1'b0; flag_q <= 1'b0; loop_en <= 1'b0; eol_ie <= 1'b0; flag_ie <= 1'b0;
      st_eol <= 1'b0; st_flag <= 1'b0; stop_pend <= 1'b0;
    end else begin
      if (cmd_wr) begin
        loop_en <= reg_wdata[2];
        eol_ie  <= reg_wdata[3];
        flag_ie <= reg_wdata[4];
      end
      if (reg_wr && reg_addr == 2'd1) base <= {reg_wdata[AW-1:2], 2'b00};
      st_eol  <= (done_now && cur_eol)  || (st_eol  && !(sts_wr && reg_wdata[1]));
      st_flag <= (done_now && cur_flag) || (st_flag && !(sts_wr && reg_wdata[2]));
      if (stop) stop_pend <= 1'b1;

      case (state)
        S_IDLE: if (start) begin
          desc_ptr  <= base;
          stop_pend <= 1'b0;
          state     <= S_DADR;
        end
        S_DADR: if (mem_ack) begin
          buf_ptr <= {mem_rdata[AW-1:2], 2'b00};
          state   <= stop_now ? S_IDLE : S_DCNT;
        end
        S_DCNT: if (mem_ack && !zero_done) begin
          wleft  <= words;
          eol_q  <= mem_rdata[31];
          flag_q <= mem_rdata[30];
          state  <= stop_now ? S_IDLE : S_DATA;
        end
        S_DATA: if (mem_ack) begin
          data_q <= mem_rdata;
          state  <= S_PUSH;
        end
        S_PUSH: if (!last_done) begin
          wleft   <= wleft - WW'(1);
          buf_ptr <= buf_ptr + AW'(4);
          state   <= stop_now ? S_IDLE : S_DATA;
        end
        default: state <= S_IDLE;
      endcase

      if (done_now) begin
        if (stop_now)      state <= S_IDLE;
        else if (!cur_eol) begin desc_ptr <= desc_ptr + AW'(8); state <= S_DADR; end
        else if (loop_en)  begin desc_ptr <= base;              state <= S_DADR; end
        else               state <= S_IDLE;
      end
      if (state != S_IDLE && stop_now &&
          ((state == S_PUSH) || (mem_ack && state != S_DATA)))
        stop_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/sg_dma_checks.sv
module sg_dma_checks #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          snk_valid,
  input logic          core_stall,
  input logic          active
);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  a_r4_stall_single: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |=> !core_stall);

  a_r3_word_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    snk_valid |-> $past(mem_ack));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mem_req && !snk_valid);

  a_r8_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> !mem_req && !core_stall);
endmodule

bind sg_dma_engine sg_dma_checks #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .snk_valid(snk_valid), .core_stall(core_stall),
  .active(active)
);

// File: tb/sim_sg_dma_engine.sv
module sim_sg_dma_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic mem_req, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_rdata = 32'd0;
  logic snk_valid, core_stall, irq;
  logic [31:0] snk_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  sg_dma_engine #(.AW(AW), .CW(24)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .snk_valid(snk_valid), .snk_data(snk_data), .core_stall(core_stall), .irq(irq)
  );

  logic [31:0] mem [0:1023];
  int lat = 0, wc = 0;
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wc >= lat) begin
        mem_ack <= 1'b1; mem_rdata <= mem[mem_addr[11:2]]; wc <= 0;
      end else wc <= wc + 1;
    end else mem_ack <= 1'b0;
  end

  logic [31:0] sink_log [0:511];
  logic [31:0] rd_log [0:1023];
  int sink_n = 0, rd_n = 0, stall_n = 0, mism = 0, dbl = 0, hold_viol = 0;
  logic p_req = 1'b0, p_ack = 1'b0, p_stall = 1'b0;
  logic [AW-1:0] p_addr = '0;
  always @(negedge clk) if (rst_n) begin
    if (snk_valid && sink_n < 512) begin sink_log[sink_n] = snk_data; sink_n++; end
    if (mem_ack && mem_req && rd_n < 1024) begin rd_log[rd_n] = mem_addr; rd_n++; end
    if (core_stall) stall_n++;
    if (core_stall != snk_valid) mism++;
    if (core_stall && p_stall) dbl++;
    if (p_req && !p_ack && (!mem_req || mem_addr != p_addr)) hold_viol++;
    p_req = mem_req; p_ack = mem_ack; p_addr = mem_addr; p_stall = core_stall;
  end

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s: actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(2'd2, s);
      if (!s[0]) break;
    end
  endtask

  task automatic load_table();
    mem[64] = 32'h200; mem[65] = 32'h3F00_0008;
    mem[66] = 32'h300; mem[67] = 32'hC000_0005;
  endtask

  task automatic t_reset();
    logic [31:0] s;
    rd(2'd2, s);
    chk(s == 0, "R1 status", s, 0);
    chk({mem_req, snk_valid, core_stall, irq} == 4'b0, "R1 outputs",
        {mem_req, snk_valid, core_stall, irq}, 0);
  endtask

  task automatic t_basic(input string tag);
    logic [31:0] s;
    int s0 = sink_n, r0 = rd_n, st0 = stall_n;
    load_table();
    wr(2'd2, 32'h6);
    wr(2'd1, 32'h102);
    wr(2'd0, 32'h1);
    wait_idle();
    chk(rd_log[r0] == 32'h100 && rd_log[r0+1] == 32'h104, {tag, " R2 desc fetch"}, rd_log[r0+1], 32'h104);
    chk(rd_log[r0+2] == 32'h200, {tag, " R3 first data addr"}, rd_log[r0+2], 32'h200);
    chk(sink_n - s0 == 4, {tag, " R9 word count ignores reserved bits"}, sink_n - s0, 4);
    chk(sink_log[s0] == 32'hA500_0080 && sink_log[s0+1] == 32'hA500_0081, {tag, " R3 buf0 data"}, sink_log[s0+1], 32'hA500_0081);
    chk(sink_log[s0+2] == 32'hA500_00C0 && sink_log[s0+3] == 32'hA500_00C1, {tag, " R3 buf1 rounded up"}, sink_log[s0+3], 32'hA500_00C1);
    chk(stall_n - st0 == 4 && mism == 0 && dbl == 0, {tag, " R4 stall per word"}, stall_n - st0, 4);
    rd(2'd2, s);
    chk(s == 32'h6, {tag, " R6 R9 status after eol"}, s, 32'h6);
    chk(irq == 1'b0, {tag, " R10 irq masked"}, irq, 0);
    chk(hold_viol == 0, {tag, " R11 request held"}, hold_viol, 0);
  endtask

  task automatic t_irq();
    wr(2'd0, 32'h08); #1 chk(irq == 1'b1, "R10 eol irq", irq, 1);
    wr(2'd2, 32'h2);  #1 chk(irq == 1'b0, "R10 eol w1c", irq, 0);
    wr(2'd0, 32'h10); #1 chk(irq == 1'b1, "R10 flag irq", irq, 1);
    wr(2'd2, 32'h4);  #1 chk(irq == 1'b0, "R10 flag w1c", irq, 0);
  endtask

  task automatic t_zero();
    logic [31:0] s;
    int s0 = sink_n, r0 = rd_n;
    bit saw_buf0 = 0, saw_next = 0;
    mem[96] = 32'h200; mem[97] = 32'h0;
    mem[98] = 32'h300; mem[99] = 32'h8000_0004;
    wr(2'd1, 32'h180);
    wr(2'd0, 32'h1);
    wait_idle();
    for (int i = r0; i < rd_n; i++) begin
      if (rd_log[i] == 32'h200) saw_buf0 = 1;
      if (rd_log[i] == 32'h188) saw_next = 1;
    end
    chk(!saw_buf0, "R5 no data read for zero count", saw_buf0, 0);
    chk(saw_next, "R5 next descriptor at +8", saw_next, 1);
    chk(sink_n - s0 == 1 && sink_log[s0] == 32'hA500_00C0, "R5 single word", sink_log[s0], 32'hA500_00C0);
    rd(2'd2, s);
    chk(s == 32'h2, "R9 no flag without bit 30", s, 32'h2);
    wr(2'd2, 32'h6);
  endtask

  task automatic t_loop_stop();
    logic [31:0] s;
    int s0, r0, n0, n1, rn;
    int wraps = 0;
    load_table();
    s0 = sink_n; r0 = rd_n;
    wr(2'd1, 32'h100);
    wr(2'd0, 32'h5);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (sink_n - s0 >= 7) break;
    end
    chk(sink_log[s0+4] == sink_log[s0] && sink_log[s0+5] == sink_log[s0+1], "R7 data repeats", sink_log[s0+4], sink_log[s0]);
    for (int i = r0 + 1; i < rd_n; i++) if (rd_log[i] == 32'h100) wraps++;
    chk(wraps >= 1, "R7 refetch from base", wraps, 1);
    n0 = sink_n;
    wr(2'd0, 32'h6);
    wait_idle();
    n1 = sink_n; rn = rd_n;
    chk(n1 - n0 <= 1, "R8 at most one word after stop", n1 - n0, 1);
    repeat (20) @(negedge clk);
    chk(sink_n == n1 && rd_n == rn && !mem_req, "R8 quiet after stop", sink_n, n1);
    rd(2'd2, s);
    chk(s[0] == 1'b0, "R8 active clear", s, 0);
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h6);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA500_0000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic("lat0");
    t_irq();
    t_zero();
    lat = 3;
    t_basic("lat3");
    lat = 1;
    t_loop_stop();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule